// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Timebase

This block produces a pulse-width-modulated output from an 8-bit timer that counts up to a programmable period value and then restarts. The timer advances once per timer step. A step lasts four input clocks times a selectable prescale factor of 1, 4 or 16. The high time is set by a 10-bit duty value that the bus writes in two parts: an 8-bit upper part and a 2-bit lower part. The duty value is double-buffered. Bus writes land in a staging buffer. That buffer is copied into the active duty latch only when the timer wraps at the end of a period, so a change made partway through a period never shortens or stretches the pulse that is already running.

The 10-bit duty is compared against the timer extended by two fine bits. The fine bits come from the sub-step counter: the clock phase when the prescale factor is 1, and the prescaler's own bits otherwise. The duty therefore resolves single prescaled input clocks. Each period wrap also feeds a postscaler, which raises a sticky match flag once every N wraps.

Top module: `pwm_db_timebase`

## Requirements
- R1: Prescale select 2'b00 gives a factor of 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16. The timer advances by one every 4 × factor input clocks. After the timer has held the period value for one full step it returns to zero, so a period lasts (period + 1) × 4 × factor clocks.
- R2: On the clock edge that ends a period, the active duty latch takes the staged duty value and the output goes high if that value is non-zero.
- R3: A staged duty of zero keeps the output low for the whole following period.
- R4: The duty is {upper 8 bits, lower 2 bits}. The output stays high for exactly duty × factor input clocks from the start of the period.
- R5: Duty writes may occur at any cycle but change the active duty (readable on `active_duty`) only at the next period end. A write made on the very edge that ends a period is applied one period later.
- R6: When the duty is at least 4 × (period + 1), the output stays high for the entire period.
- R7: With a 4-bit postscale value p, the match flag is set on every (p + 1)-th period end. It stays set until `flag_clr` is pulsed. If a set and a clear occur on the same edge, the set wins.
- R8: After reset, the output is low, the flag is clear, the timer is zero and the active duty is zero. The period register resets to all ones, the prescale factor to 1 and the postscale value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_we | input | 1 | Write strobe for the period register |
| period_wdata | input | 8 | Period value |
| cfg_we | input | 1 | Write strobe for prescale and postscale selects |
| cfg_pre_sel | input | 2 | Prescale select |
| cfg_post_sel | input | 4 | Postscale value (divide by value + 1) |
| duty_hi_we | input | 1 | Write strobe for the upper 8 duty bits |
| duty_hi_wdata | input | 8 | Upper duty bits |
| duty_lo_we | input | 1 | Write strobe for the lower 2 duty bits |
| duty_lo_wdata | input | 2 | Lower duty bits |
| flag_clr | input | 1 | Clears the match flag |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Postscaled period-match flag |
| timer_value | output | 8 | Current timer count |
| active_duty | output | 10 | Active (latched) duty value, read-only |

## Verification
Every result of this block is registered. The output level, the timer, the active duty and the flag each reflect the inputs present at a rising edge and become visible just after that edge, with no further pipeline delay. For each rising edge, the driver advances a requirement-level model: clocks elapsed in the period, staged and active duty, postscale count. It then queues the expected output, flag, timer and active duty for that edge. The monitor pops the entry at the following falling edge and compares, so each result is checked exactly one edge after the stimulus that causes it. Strobes change only at falling edges.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // Prescale select encodings (factor 1, 4, 16; 2'b11 also selects 16)
   localparam logic [1:0] PRE_DIV1  = 2'b00;
   localparam logic [1:0] PRE_DIV4  = 2'b01;
   localparam logic [1:0] PRE_DIV16 = 2'b10;
   localparam int         FINE_BITS = 2;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int FINE_W  = 2,
   parameter int NUM_OPT = 3,
   parameter int SEL_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   output logic              tick,
   output logic [FINE_W-1:0] fine_nxt
);
   localparam int SUB_W = FINE_W * NUM_OPT;

   logic [SUB_W-1:0]  sub_q, sub_nxt, lim;
   logic [SUB_W-1:0]  lim_opt  [NUM_OPT];
   logic [FINE_W-1:0] fine_opt [NUM_OPT];
   logic [SEL_W-1:0]  sel_c;

   if (NUM_OPT < 1 || NUM_OPT > (1 << SEL_W)) begin : g_bad_opt
      $error("pwm_prescale: NUM_OPT does not fit the select width");
   end

   assign sel_c = (int'(sel) >= NUM_OPT) ? SEL_W'(NUM_OPT - 1) : sel;

   for (genvar k = 0; k < NUM_OPT; k++) begin : g_opt
      assign lim_opt[k]  = {SUB_W{1'b1}} >> (FINE_W * (NUM_OPT - 1 - k));
      assign fine_opt[k] = sub_nxt[FINE_W*(k+1)-1 -: FINE_W];
   end

   always_comb begin
      lim      = lim_opt[NUM_OPT-1];
      fine_nxt = fine_opt[NUM_OPT-1];
      for (int k = 0; k < NUM_OPT; k++) begin
         if (sel_c == SEL_W'(k)) begin
            lim      = lim_opt[k];
            fine_nxt = fine_opt[k];
         end
      end
   end

   assign tick    = (sub_q >= lim);
   assign sub_nxt = tick ? '0 : sub_q + SUB_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sub_q <= '0;
      else        sub_q <= sub_nxt;
   end

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
   parameter int TMR_W  = 8,
   parameter int FINE_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hi_we,
   input  logic [TMR_W-1:0]        hi_wdata,
   input  logic                    lo_we,
   input  logic [FINE_W-1:0]       lo_wdata,
   input  logic                    wrap,
   input  logic [TMR_W+FINE_W-1:0] cnt_nxt,
   output logic [TMR_W+FINE_W-1:0] act,
   output logic                    pwm_out
);
   localparam int DUTY_W = TMR_W + FINE_W;

   logic [DUTY_W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         if (hi_we) stage_q[DUTY_W-1:FINE_W] <= hi_wdata;
         if (lo_we) stage_q[FINE_W-1:0]      <= lo_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= '0;
         pwm_out <= 1'b0;
      end else if (wrap) begin
         act     <= stage_q;
         pwm_out <= |stage_q;
      end else if (pwm_out && cnt_nxt == act) begin
         pwm_out <= 1'b0;
      end
   end

   // R2
   out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> $past(wrap));
   // R3
   zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && stage_q == '0) |=> !pwm_out);
   // R5
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act));
endmodule

// File: rtl/pwm_postscale.sv
module pwm_postscale #(
   parameter int POST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wrap,
   input  logic [POST_W-1:0] post_sel,
   input  logic              flag_clr,
   output logic              flag
);
   logic [POST_W-1:0] cnt_q;
   logic              hit;

   if (POST_W < 1) begin : g_bad_post
      $error("pwm_postscale: POST_W must be at least 1");
   end

   assign hit = wrap && (cnt_q == post_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         flag  <= 1'b0;
      end else begin
         if (wrap) cnt_q <= hit ? '0 : cnt_q + POST_W'(1);
         if (hit)           flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   // R7
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(wrap));
endmodule

// File: rtl/pwm_db_timebase.sv
module pwm_db_timebase #(
   parameter int         TMR_W      = 8,
   parameter int         FINE_W     = pwm_pkg::FINE_BITS,
   parameter int         PRE_OPTS   = 3,
   parameter int         PRE_SEL_W  = 2,
   parameter int         POST_W     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    period_we,
   input  logic [TMR_W-1:0]        period_wdata,
   input  logic                    cfg_we,
   input  logic [PRE_SEL_W-1:0]    cfg_pre_sel,
   input  logic [POST_W-1:0]       cfg_post_sel,
   input  logic                    duty_hi_we,
   input  logic [TMR_W-1:0]        duty_hi_wdata,
   input  logic                    duty_lo_we,
   input  logic [FINE_W-1:0]       duty_lo_wdata,
   input  logic                    flag_clr,
   output logic                    pwm_out,
   output logic                    match_flag,
   output logic [TMR_W-1:0]        timer_value,
   output logic [TMR_W+FINE_W-1:0] active_duty
);
   localparam int DUTY_W = TMR_W + FINE_W;

   if (TMR_W < 2 || FINE_W < 1) begin : g_bad_width
      $error("pwm_db_timebase: timer or fine width too small");
   end

   logic [TMR_W-1:0]     period_q, tmr_q, tmr_nxt;
   logic [PRE_SEL_W-1:0] pre_q;
   logic [POST_W-1:0]    post_q;
   logic                 tick, wrap;
   logic [FINE_W-1:0]    fine_nxt;
   logic [DUTY_W-1:0]    cnt_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '1;
         pre_q    <= pwm_pkg::PRE_DIV1;
         post_q   <= '0;
      end else begin
         if (period_we) period_q <= period_wdata;
         if (cfg_we) begin
            pre_q  <= cfg_pre_sel;
            post_q <= cfg_post_sel;
         end
      end
   end

   pwm_prescale #(.FINE_W(FINE_W), .NUM_OPT(PRE_OPTS), .SEL_W(PRE_SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(pre_q), .tick(tick), .fine_nxt(fine_nxt));

   assign wrap    = tick && (tmr_q == period_q);
   assign tmr_nxt = wrap ? '0 : (tick ? tmr_q + TMR_W'(1) : tmr_q);
   assign cnt_nxt = {tmr_nxt, fine_nxt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_q <= '0;
      else        tmr_q <= tmr_nxt;
   end

   pwm_duty #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_duty (
      .clk(clk), .rst_n(rst_n),
      .hi_we(duty_hi_we), .hi_wdata(duty_hi_wdata),
      .lo_we(duty_lo_we), .lo_wdata(duty_lo_wdata),
      .wrap(wrap), .cnt_nxt(cnt_nxt),
      .act(active_duty), .pwm_out(pwm_out));

   pwm_postscale #(.POST_W(POST_W)) u_post (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .post_sel(post_q),
      .flag_clr(flag_clr), .flag(match_flag));

   assign timer_value = tmr_q;

   // R1
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(timer_value));
   // R1
   timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (timer_value == '0));
endmodule

// File: tb/test_pwm_db_timebase.sv
module test_pwm_db_timebase;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       rst_n = 1'b0;
   logic       period_we = 0, cfg_we = 0, duty_hi_we = 0, duty_lo_we = 0, flag_clr = 0;
   logic [7:0] period_wdata = 0, duty_hi_wdata = 0;
   logic [1:0] cfg_pre_sel = 0, duty_lo_wdata = 0;
   logic [3:0] cfg_post_sel = 0;
   logic       pwm_out, match_flag;
   logic [7:0] timer_value;
   logic [9:0] active_duty;

   pwm_db_timebase i_pwm_db_timebase (
      .clk(clk), .rst_n(rst_n),
      .period_we(period_we), .period_wdata(period_wdata),
      .cfg_we(cfg_we), .cfg_pre_sel(cfg_pre_sel), .cfg_post_sel(cfg_post_sel),
      .duty_hi_we(duty_hi_we), .duty_hi_wdata(duty_hi_wdata),
      .duty_lo_we(duty_lo_we), .duty_lo_wdata(duty_lo_wdata),
      .flag_clr(flag_clr),
      .pwm_out(pwm_out), .match_flag(match_flag),
      .timer_value(timer_value), .active_duty(active_duty));

   typedef struct {
      int    out;
      int    flag;
      int    tmr;
      int    act;
      string out_req;
   } exp_t;

   exp_t  sbq[$];
   exp_t  mon_e;
   int    n_vec = 0, n_bad = 0;
   int    m_c, m_act, m_buf, m_per, m_pre, m_post, m_wc, m_flag;
   string scen_req;

   task automatic check(string req, string what, int got, int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         mon_e = sbq.pop_front();
         check(mon_e.out_req, "pwm_out", int'(pwm_out), mon_e.out);
         check("R7", "match_flag", int'(match_flag), mon_e.flag);
         check("R1", "timer_value", int'(timer_value), mon_e.tmr);
         check("R5", "active_duty", int'(active_duty), mon_e.act);
      end
   end

   function automatic int pre_factor(logic [1:0] s);
      return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 16;
   endfunction

   // One rising edge: advance the requirement model with the inputs present at it.
   task automatic cycle();
      exp_t e;
      int   per_len;
      bit   set_now;
      @(posedge clk);
      per_len = (m_per + 1) * 4 * m_pre;
      set_now = 0;
      if (m_c + 1 >= per_len) begin
         m_c   = 0;
         m_act = m_buf;
         m_wc++;
         if (m_wc == m_post + 1) begin
            m_flag  = 1;
            m_wc    = 0;
            set_now = 1;
         end
      end else begin
         m_c++;
      end
      if (!set_now && flag_clr) m_flag = 0;
      if (period_we) m_per = int'(period_wdata);
      if (cfg_we) begin
         m_pre  = pre_factor(cfg_pre_sel);
         m_post = int'(cfg_post_sel);
      end
      if (duty_hi_we) m_buf = (int'(duty_hi_wdata) << 2) | (m_buf & 3);
      if (duty_lo_we) m_buf = (m_buf & 32'h3FC) | int'(duty_lo_wdata);
      e.out     = (m_act != 0 && m_c < m_act * m_pre) ? 1 : 0;
      e.flag    = m_flag;
      e.tmr     = m_c / (4 * m_pre);
      e.act     = m_act;
      e.out_req = (m_c == 0) ? "R2" : scen_req;
      sbq.push_back(e);
      @(negedge clk);
      period_we = 0; cfg_we = 0; duty_hi_we = 0; duty_lo_we = 0; flag_clr = 0;
   endtask

   task automatic start(int per, logic [1:0] pre, logic [3:0] post, int duty, string req);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8", "reset pwm_out", int'(pwm_out), 0);
      check("R8", "reset match_flag", int'(match_flag), 0);
      check("R8", "reset timer_value", int'(timer_value), 0);
      check("R8", "reset active_duty", int'(active_duty), 0);
      m_c = 0; m_act = 0; m_buf = 0; m_per = 255; m_pre = 1; m_post = 0; m_wc = 0; m_flag = 0;
      scen_req      = req;
      period_we     = 1; period_wdata  = 8'(per);
      cfg_we        = 1; cfg_pre_sel   = pre; cfg_post_sel = post;
      duty_hi_we    = 1; duty_hi_wdata = 8'(duty >> 2);
      duty_lo_we    = 1; duty_lo_wdata = 2'(duty);
      rst_n         = 1'b1;
      cycle();
   endtask

   task automatic run(int n, int clr_every);
      for (int i = 0; i < n; i++) begin
         if (clr_every > 0 && (i % clr_every) == clr_every - 1) flag_clr = 1;
         cycle();
      end
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
   end

   initial begin
      // R4: factor 1, period 3 (16 clocks), duty 6
      start(3, 2'b00, 4'd0, 6, "R4");
      run(38, 10);
      // R5: mid-period duty write (duty 3), active only from the next period
      scen_req = "R5";
      duty_hi_we = 1; duty_hi_wdata = 8'd0;
      duty_lo_we = 1; duty_lo_wdata = 2'd3;
      cycle();
      run(60, 7);
      // R4: factor 4, period 9, duty 37, postscale 3
      start(9, 2'b01, 4'd2, 37, "R4");
      run(700, 50);
      // R3: zero duty, postscale 16 boundary for R7
      start(5, 2'b00, 4'd15, 0, "R3");
      run(420, 0);
      // R6: duty beyond the period keeps the output high
      start(2, 2'b00, 4'd0, 1023, "R6");
      run(50, 0);
      // R4: factor 16, period 1, duty 5
      start(1, 2'b10, 4'd1, 5, "R4");
      run(400, 90);
      // R1: select 2'b11 also gives factor 16, period 0
      start(0, 2'b11, 4'd0, 2, "R1");
      run(200, 0);
      @(negedge clk);
      finish_up();
   end
endmodule